// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block holds the micro-address of the instruction now executing in a microcoded stack-machine controller, and on every clock it picks the address of the one that follows. The current microinstruction supplies three fields. The first is a 3-bit pair code that names two address sources: one is taken when a selected condition holds and the other when it fails. The second is a 4-bit code that picks the condition. The third is an 8-bit constant that serves as the jump target. The possible sources are the incremented address, the constant, the same address again (repeat), a fixed handler for unimplemented functions, and the start of the next opcode.

A trap request aborts the instruction in flight and sends the sequencer to that trap's handler. Traps take priority over everything else. When the selected source is the start of the next opcode, the block checks its preconditions before dispatch. The general preconditions are trap on entry, interrupt pending, jump refill and instruction refill of the instruction buffer. The opcode's own precondition comes from the opcode decode table. If any of them is unmet, the block dispatches a pseudo-opcode in place of the opcode. The address, a repeat flag and a pseudo-dispatch flag are registered together.

Top module: `useq_sequencer`

## Requirements
- R1: A clock edge with `rst` high sets `uaddr_o` to 0 and clears `repeat_o` and `pseudo_o`.
- R2: The condition is true for code 0. For codes 1 to 12 it equals `cond_flags[code-1]`. For codes 13 to 15 it is false.
- R3: Pair code 0 always advances to `uaddr_o+1`, which wraps from the top address to 0. Pair code 1 loads the zero-extended `k_const` when the condition is true and advances to `uaddr_o+1` when it is false.
- R4: Pair code 2 selects opcode dispatch when the condition is true. Pair code 3 advances to `uaddr_o+1` when it is true. For both codes, a false condition loads `UFN_ADDR`.
- R5: Pair code 4 selects repeat or advance, and pair code 5 selects repeat or dispatch. On a repeat, `uaddr_o` is unchanged and `repeat_o` is 1. On any other step, `repeat_o` is 0.
- R6: Pair codes 6 and 7 advance to `uaddr_o+1`.
- R7: A nonzero `trap_req` loads `TRAP_BASE+i`, where i is the lowest set bit (bit 0 page refill, bit 1 write fault, bit 2 page fault). It overrides every pair code, and `repeat_o` and `pseudo_o` go to 0.
- R8: A dispatch with every precondition met loads the zero-extended `op_start`, with `pseudo_o` at 0.
- R9: A dispatch with a general precondition pending loads a pseudo-opcode address and sets `pseudo_o`. The `gen_pre` bits are: bit 3 trap on entry, bit 2 interrupt, bit 0 jump refill, bit 1 instruction refill. Priority runs in that order, and the addresses are `GEN_BASE`+0, +1, +2 and +3 respectively.
- R10: With no general precondition pending, `op_precond` selects the check. Code 1 needs `frame_status[0]` (an empty frame is present). Code 2 needs `frame_status[1]` (the previous frame is in the machine). Code 3 needs `frame_status[2]` (all previous frames are empty). Code 4 needs `frame_status[3]` low (the slow-return bit is off). If the check fails, the block loads `PRE_BASE+code` and sets `pseudo_o`. Codes 0, 5, 6 and 7 are always met.
- R11: `pseudo_o` is 1 only after a step that dispatched a pseudo-opcode. A step without dispatch leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_sel | input | 3 | Next-address pair code |
| cond_sel | input | 4 | Condition select code |
| k_const | input | 8 | Jump constant from the microinstruction |
| cond_flags | input | NFLAG (12) | Condition flags for codes 1..12 |
| trap_req | input | NTRAP (3) | Trap requests, bit 0 has highest priority |
| gen_pre | input | 4 | General dispatch preconditions |
| op_start | input | 8 | Opcode start address from the decode table |
| op_precond | input | 3 | Opcode precondition code |
| frame_status | input | 4 | Frame state used by the opcode precondition checks |
| uaddr_o | output | ADDR_W (8) | Current micro-address (registered) |
| repeat_o | output | 1 | Last step was a repeat |
| pseudo_o | output | 1 | Last step dispatched a pseudo-opcode |

## Verification
Random microinstructions cover all pair codes and condition codes, with flag vectors and trap and precondition mixes biased so that both sides of each pair are taken often. This separates errors in the condition lookup from errors in the pairing table. Directed steps then force the edge cases. One checks wrap of the incremented address. One checks the undefined condition codes and pair codes. Several stack traps and general preconditions together, so that a wrong priority order gives a wrong handler address. Each opcode precondition code is run both passing and failing, which shows whether the polarity and the `PRE_BASE` offset are right.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W = 8;

    typedef enum logic [2:0] {
        NA_NEXT     = 3'd0,
        NA_JUMPK    = 3'd1,
        NA_DONE_UFN = 3'd2,
        NA_NEXT_UFN = 3'd3,
        NA_RPT_NEXT = 3'd4,
        NA_RPT_DONE = 3'd5
    } na_pair_e;

    typedef enum logic [2:0] {
        SRC_NEXT,
        SRC_JUMPK,
        SRC_DONE,
        SRC_UFN,
        SRC_REPEAT
    } src_e;

    typedef enum logic [2:0] {
        PC_NONE        = 3'd0,
        PC_EMPTY_FRAME = 3'd1,
        PC_PREV_IN     = 3'd2,
        PC_PREV_EMPTY  = 3'd3,
        PC_SLOWRET_OFF = 3'd4
    } precond_e;

    // bit positions in the general precondition vector
    localparam int GP_JREFILL = 0;
    localparam int GP_IREFILL = 1;
    localparam int GP_IRQ     = 2;
    localparam int GP_TRAPENT = 3;

    typedef struct packed {
        logic rpt;
        logic pseudo;
    } useq_flags_t;

    function automatic src_e pick_src(input logic [2:0] pair, input logic ok);
        src_e s;
        case (na_pair_e'(pair))
            NA_JUMPK:    s = ok ? SRC_JUMPK  : SRC_NEXT;
            NA_DONE_UFN: s = ok ? SRC_DONE   : SRC_UFN;
            NA_NEXT_UFN: s = ok ? SRC_NEXT   : SRC_UFN;
            NA_RPT_NEXT: s = ok ? SRC_REPEAT : SRC_NEXT;
            NA_RPT_DONE: s = ok ? SRC_REPEAT : SRC_DONE;
            default:     s = SRC_NEXT;
        endcase
        return s;
    endfunction

    function automatic logic precond_met(input logic [2:0] code, input logic [3:0] fst);
        logic m;
        case (precond_e'(code))
            PC_EMPTY_FRAME: m = fst[0];
            PC_PREV_IN:     m = fst[1];
            PC_PREV_EMPTY:  m = fst[2];
            PC_SLOWRET_OFF: m = !fst[3];
            default:        m = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel #(
    parameter int NFLAG = 12
) (
    input  logic [3:0]       code,
    input  logic [NFLAG-1:0] flags,
    output logic             cond_ok
);
    always_comb begin
        cond_ok = 1'b0;
        if (code == 4'd0) begin
            cond_ok = 1'b1;
        end else begin
            for (int i = 0; i < NFLAG; i++) begin
                if (32'(code) == i + 1) cond_ok = flags[i];
            end
        end
    end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int              ADDR_W   = UA_W,
    parameter logic [ADDR_W-1:0] GEN_BASE = ADDR_W'(8'hE0),
    parameter logic [ADDR_W-1:0] PRE_BASE = ADDR_W'(8'hE8)
) (
    input  logic [3:0]        gen_pre,
    input  logic [2:0]        pre_code,
    input  logic [3:0]        frame_status,
    input  logic [7:0]        op_start,
    output logic [ADDR_W-1:0] disp_addr,
    output logic              disp_pseudo
);
    always_comb begin
        disp_pseudo = 1'b1;
        if (gen_pre[GP_TRAPENT])
            disp_addr = GEN_BASE;
        else if (gen_pre[GP_IRQ])
            disp_addr = GEN_BASE + ADDR_W'(1);
        else if (gen_pre[GP_JREFILL])
            disp_addr = GEN_BASE + ADDR_W'(2);
        else if (gen_pre[GP_IREFILL])
            disp_addr = GEN_BASE + ADDR_W'(3);
        else if (!precond_met(pre_code, frame_status))
            disp_addr = PRE_BASE + ADDR_W'(pre_code);
        else begin
            disp_addr   = ADDR_W'(op_start);
            disp_pseudo = 1'b0;
        end
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int                ADDR_W    = UA_W,
    parameter int                NFLAG     = 12,
    parameter int                NTRAP     = 3,
    parameter logic [ADDR_W-1:0] UFN_ADDR  = ADDR_W'(8'hF0),
    parameter logic [ADDR_W-1:0] TRAP_BASE = ADDR_W'(8'hF8),
    parameter logic [ADDR_W-1:0] GEN_BASE  = ADDR_W'(8'hE0),
    parameter logic [ADDR_W-1:0] PRE_BASE  = ADDR_W'(8'hE8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        nxt_sel,
    input  logic [3:0]        cond_sel,
    input  logic [7:0]        k_const,
    input  logic [NFLAG-1:0]  cond_flags,
    input  logic [NTRAP-1:0]  trap_req,
    input  logic [3:0]        gen_pre,
    input  logic [7:0]        op_start,
    input  logic [2:0]        op_precond,
    input  logic [3:0]        frame_status,
    output logic [ADDR_W-1:0] uaddr_o,
    output logic              repeat_o,
    output logic              pseudo_o
);
    logic              cond_ok;
    logic [ADDR_W-1:0] disp_addr;
    logic              disp_pseudo;
    logic              trap_any;
    logic [ADDR_W-1:0] trap_addr;
    src_e              src;
    logic [ADDR_W-1:0] addr_d;
    useq_flags_t       flags_d;
    useq_flags_t       flags_q;
    logic [ADDR_W-1:0] uaddr_q;

    useq_cond_sel #(.NFLAG(NFLAG)) u_cond (
        .code    (cond_sel),
        .flags   (cond_flags),
        .cond_ok (cond_ok)
    );

    useq_dispatch #(
        .ADDR_W   (ADDR_W),
        .GEN_BASE (GEN_BASE),
        .PRE_BASE (PRE_BASE)
    ) u_disp (
        .gen_pre      (gen_pre),
        .pre_code     (op_precond),
        .frame_status (frame_status),
        .op_start     (op_start),
        .disp_addr    (disp_addr),
        .disp_pseudo  (disp_pseudo)
    );

    // lowest-numbered trap wins: scan downward so the last hit sticks
    always_comb begin
        trap_any  = |trap_req;
        trap_addr = TRAP_BASE;
        for (int i = NTRAP - 1; i >= 0; i--) begin
            if (trap_req[i]) trap_addr = TRAP_BASE + ADDR_W'(i);
        end
    end

    assign src = pick_src(nxt_sel, cond_ok);

    always_comb begin
        flags_d = '0;
        if (trap_any) begin
            addr_d = trap_addr;
        end else begin
            case (src)
                SRC_JUMPK:  addr_d = ADDR_W'(k_const);
                SRC_UFN:    addr_d = UFN_ADDR;
                SRC_REPEAT: begin
                    addr_d      = uaddr_q;
                    flags_d.rpt = 1'b1;
                end
                SRC_DONE: begin
                    addr_d         = disp_addr;
                    flags_d.pseudo = disp_pseudo;
                end
                default:    addr_d = uaddr_q + ADDR_W'(1);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uaddr_q <= '0;
            flags_q <= '0;
        end else begin
            uaddr_q <= addr_d;
            flags_q <= flags_d;
        end
    end

    assign uaddr_o  = uaddr_q;
    assign repeat_o = flags_q.rpt;
    assign pseudo_o = flags_q.pseudo;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (uaddr_o == '0 && !repeat_o && !pseudo_o));

    assert_jumpk_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_req == '0 && nxt_sel == 3'd1 && cond_ok)
        |=> uaddr_o == ADDR_W'($past(k_const)));

    assert_ufn_R4: assert property (@(posedge clk) disable iff (rst)
        (trap_req == '0 && nxt_sel == 3'd3 && !cond_ok) |=> uaddr_o == UFN_ADDR);

    assert_repeat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        repeat_o |-> uaddr_o == $past(uaddr_o));

    assert_trap_first_R7: assert property (@(posedge clk) disable iff (rst)
        trap_req[0] |=> (uaddr_o == TRAP_BASE && !repeat_o && !pseudo_o));

    assert_no_pseudo_R11: assert property (@(posedge clk) disable iff (rst)
        (trap_req == '0 && (nxt_sel == 3'd0 || nxt_sel == 3'd1 || nxt_sel == 3'd3))
        |=> !pseudo_o);

endmodule

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
    localparam logic [7:0] UFN_A  = 8'hF0;
    localparam logic [7:0] TRAP_A = 8'hF8;
    localparam logic [7:0] GEN_A  = 8'hE0;
    localparam logic [7:0] PRE_A  = 8'hE8;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  nxt_sel;
    logic [3:0]  cond_sel;
    logic [7:0]  k_const;
    logic [11:0] cond_flags;
    logic [2:0]  trap_req;
    logic [3:0]  gen_pre;
    logic [7:0]  op_start;
    logic [2:0]  op_precond;
    logic [3:0]  frame_status;
    logic [7:0]  uaddr_o;
    logic        repeat_o;
    logic        pseudo_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] m_addr = 8'd0;

    always #2.5 clk = ~clk;

    useq_sequencer #(
        .ADDR_W(8), .NFLAG(12), .NTRAP(3),
        .UFN_ADDR(UFN_A), .TRAP_BASE(TRAP_A), .GEN_BASE(GEN_A), .PRE_BASE(PRE_A)
    ) dut (
        .clk(clk), .rst(rst), .nxt_sel(nxt_sel), .cond_sel(cond_sel),
        .k_const(k_const), .cond_flags(cond_flags), .trap_req(trap_req),
        .gen_pre(gen_pre), .op_start(op_start), .op_precond(op_precond),
        .frame_status(frame_status), .uaddr_o(uaddr_o), .repeat_o(repeat_o),
        .pseudo_o(pseudo_o)
    );

    function automatic logic cond_of(input logic [3:0] c, input logic [11:0] f);
        if (c == 4'd0) return 1'b1;
        if (c <= 4'd12) return f[c - 4'd1];
        return 1'b0;
    endfunction

    // expected {addr, repeat, pseudo} and the requirement the step exercises
    function automatic logic [9:0] model(
        input logic [7:0] cur, input logic [2:0] s, input logic [3:0] c,
        input logic [7:0] k, input logic [11:0] f, input logic [2:0] t,
        input logic [3:0] g, input logic [7:0] st, input logic [2:0] p,
        input logic [3:0] fs, output string tag);
        logic ok;
        logic met;
        int kind; // 0 next, 1 k, 2 done, 3 ufn, 4 repeat
        ok = cond_of(c, f);
        if (t[0]) begin tag = "R7"; return {TRAP_A, 2'b00}; end
        if (t[1]) begin tag = "R7"; return {TRAP_A + 8'd1, 2'b00}; end
        if (t[2]) begin tag = "R7"; return {TRAP_A + 8'd2, 2'b00}; end
        case (s)
            3'd0: begin kind = 0; tag = "R3"; end
            3'd1: begin kind = ok ? 1 : 0; tag = "R3"; end
            3'd2: begin kind = ok ? 2 : 3; tag = "R4"; end
            3'd3: begin kind = ok ? 0 : 3; tag = "R4"; end
            3'd4: begin kind = ok ? 4 : 0; tag = "R5"; end
            3'd5: begin kind = ok ? 4 : 2; tag = "R5"; end
            default: begin kind = 0; tag = "R6"; end
        endcase
        case (kind)
            1: return {k, 2'b00};
            3: return {UFN_A, 2'b00};
            4: return {cur, 2'b10};
            2: begin
                if (g[3]) begin tag = "R9"; return {GEN_A, 2'b01}; end
                if (g[2]) begin tag = "R9"; return {GEN_A + 8'd1, 2'b01}; end
                if (g[0]) begin tag = "R9"; return {GEN_A + 8'd2, 2'b01}; end
                if (g[1]) begin tag = "R9"; return {GEN_A + 8'd3, 2'b01}; end
                case (p)
                    3'd1: met = fs[0];
                    3'd2: met = fs[1];
                    3'd3: met = fs[2];
                    3'd4: met = !fs[3];
                    default: met = 1'b1;
                endcase
                if (!met) begin tag = "R10"; return {PRE_A + {5'd0, p}, 2'b01}; end
                tag = "R8";
                return {st, 2'b00};
            end
            default: return {cur + 8'd1, 2'b00};
        endcase
    endfunction

    task automatic check(input string tag, input logic [9:0] exp);
        n_chk++;
        if ({uaddr_o, repeat_o, pseudo_o} !== exp) begin
            n_fail++;
            $display("FAIL %s: actual addr=%0h rep=%0b ps=%0b expected addr=%0h rep=%0b ps=%0b",
                     tag, uaddr_o, repeat_o, pseudo_o, exp[9:2], exp[1], exp[0]);
        end
    endtask

    task automatic step(input logic [2:0] s, input logic [3:0] c, input logic [7:0] k,
                        input logic [11:0] f, input logic [2:0] t, input logic [3:0] g,
                        input logic [7:0] st, input logic [2:0] p, input logic [3:0] fs,
                        input string force_tag);
        logic [9:0] exp;
        string tag;
        nxt_sel = s; cond_sel = c; k_const = k; cond_flags = f; trap_req = t;
        gen_pre = g; op_start = st; op_precond = p; frame_status = fs;
        exp = model(m_addr, s, c, k, f, t, g, st, p, fs, tag);
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        @(negedge clk);
        check(tag, exp);
        m_addr = exp[9:2];
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", 10'd0);
        rst = 1'b0;
        m_addr = 8'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; nxt_sel = '0; cond_sel = '0; k_const = '0; cond_flags = '0;
        trap_req = '0; gen_pre = '0; op_start = '0; op_precond = '0; frame_status = '0;
        @(negedge clk);
        do_reset();

        // R3: jump to top, then wrap on increment
        step(3'd1, 4'd0, 8'hFF, 12'h0, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R3");
        step(3'd0, 4'd0, 8'h00, 12'h0, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R3");
        // R2: flag lookup and undefined codes
        step(3'd1, 4'd12, 8'h40, 12'h800, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R2");
        step(3'd1, 4'd1, 8'h50, 12'hFFE, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R2");
        for (int c = 13; c < 16; c++)
            step(3'd1, 4'(c), 8'h77, 12'hFFF, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R2");
        // R4: UFN on false
        step(3'd2, 4'd5, 8'h00, 12'h000, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R4");
        step(3'd3, 4'd5, 8'h00, 12'h000, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R4");
        // R5: repeat holds, then repeat-or-dispatch false
        step(3'd4, 4'd0, 8'h00, 12'h000, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R5");
        step(3'd4, 4'd0, 8'h00, 12'h000, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R5");
        step(3'd5, 4'd3, 8'h00, 12'h000, 3'd0, 4'd0, 8'h3C, 3'd0, 4'd0, "R5");
        // R6: undefined pair codes
        step(3'd6, 4'd0, 8'h11, 12'h000, 3'd0, 4'd0, 8'h22, 3'd0, 4'd0, "R6");
        step(3'd7, 4'd0, 8'h11, 12'h000, 3'd0, 4'd0, 8'h22, 3'd0, 4'd0, "R6");
        // R7: trap priority over dispatch and repeat
        step(3'd2, 4'd0, 8'h00, 12'h000, 3'b110, 4'hF, 8'h22, 3'd1, 4'd0, "R7");
        step(3'd4, 4'd0, 8'h00, 12'h000, 3'b100, 4'd0, 8'h00, 3'd0, 4'd0, "R7");
        step(3'd1, 4'd0, 8'h99, 12'h000, 3'b111, 4'd0, 8'h00, 3'd0, 4'd0, "R7");
        // R8: clean dispatch
        step(3'd2, 4'd0, 8'h00, 12'h000, 3'd0, 4'd0, 8'h5A, 3'd1, 4'b0001, "R8");
        // R9: general precondition priority
        step(3'd2, 4'd0, 8'h00, 12'h000, 3'd0, 4'b1111, 8'h5A, 3'd0, 4'd0, "R9");
        step(3'd2, 4'd0, 8'h00, 12'h000, 3'd0, 4'b0111, 8'h5A, 3'd0, 4'd0, "R9");
        step(3'd2, 4'd0, 8'h00, 12'h000, 3'd0, 4'b0011, 8'h5A, 3'd0, 4'd0, "R9");
        step(3'd2, 4'd0, 8'h00, 12'h000, 3'd0, 4'b0010, 8'h5A, 3'd0, 4'd0, "R9");
        // R10: each specific precondition failing and passing
        for (int p = 1; p < 5; p++) begin
            step(3'd2, 4'd0, 8'h00, 12'h000, 3'd0, 4'd0, 8'h61, 3'(p), 4'b1000, "R10");
            step(3'd2, 4'd0, 8'h00, 12'h000, 3'd0, 4'd0, 8'h62, 3'(p), 4'b0111, "R10");
        end
        step(3'd2, 4'd0, 8'h00, 12'h000, 3'd0, 4'd0, 8'h63, 3'd6, 4'b1000, "R10");
        // R11: non-dispatch step after a pseudo dispatch clears the flag
        step(3'd2, 4'd0, 8'h00, 12'h000, 3'd0, 4'b0100, 8'h00, 3'd0, 4'd0, "R11");
        step(3'd0, 4'd0, 8'h00, 12'h000, 3'd0, 4'b0100, 8'h00, 3'd0, 4'd0, "R11");

        for (int i = 0; i < 600; i++) begin
            logic [2:0] t;
            logic [3:0] g;
            t = (($urandom % 8) == 0) ? 3'($urandom) : 3'd0;
            g = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
            step(3'($urandom), 4'($urandom % 16), 8'($urandom), 12'($urandom), t, g,
                 8'($urandom), 3'($urandom), 4'($urandom), "");
        end

        // R1: reset in mid-run
        step(3'd1, 4'd0, 8'hA5, 12'h000, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R3");
        step(3'd4, 4'd0, 8'h00, 12'h000, 3'd0, 4'd0, 8'h00, 3'd0, 4'd0, "R5");
        do_reset();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule